// File: doc/BRIEF.md
# Sparse Two-Level Routing Crossbar

This block steers a shared pool of 65 global signals onto 40 output rows that feed the inputs of a wide product-term (AND) array. A full crossbar would give each row a 67-way choice. Here each row instead sees a short list of 8 candidates, and the cost drops to an 8:1 selector per row.

The first level is fixed when the design is elaborated. Every row gets constant one, constant zero and six routed signals. Routed candidate k of a row always comes from the k-th contiguous slice of the pool. The offset inside that slice is skewed by the row number, so each pool signal reaches only a few rows.

The second level is a one-hot 8-bit select word per row, written through a simple load port. Until the configuration-done input is raised, every row is held at logic 1, which is the neutral value for an AND input. A row whose select word is not one-hot is also held at 1 and is flagged on a per-row error output.

Top module: `xbar_sparse`

## Requirements
- R1: A synchronous active-low reset clears every row's select word to zero. Right after reset, with cfg_done low, row_out is all ones and row_err is all zeros.
- R2: While cfg_done is low, every bit of row_out is 1 and every bit of row_err is 0, whatever the stored select words and sig_in hold.
- R3: With cfg_done high, select word 8'h01 (bit 0) makes the row output 1.
- R4: With cfg_done high, select word 8'h02 (bit 1) makes the row output 0.
- R5: With cfg_done high, select word with only bit 2+k set (k = 0..5) makes row r output sig_in[11*k + ((r + 3*k) mod L)]. L is 11 for k = 0..4 and 10 for k = 5.
- R6: With cfg_done high, a select word that has no bits set or more than one bit set drives row_err[r] to 1 and row_out[r] to 1.
- R7: A write (cfg_we high at a rising edge, cfg_row below 40) stores cfg_sel as that row's select word, effective from that edge. All other rows keep their words.
- R8: A write with cfg_row of 40 or more changes no select word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 65 | Shared global signal pool |
| cfg_we | input | 1 | Select-word write strobe |
| cfg_row | input | 6 | Row addressed by a write |
| cfg_sel | input | 8 | One-hot select word to store |
| cfg_done | input | 1 | Configuration complete; releases rows from the safe value |
| row_out | output | 40 | Routed row outputs |
| row_err | output | 40 | Per-row flag for a select word that is not one-hot |

## Verification
Some properties are checked on every cycle: the forced-high state before configuration completes, an erroring row staying at its safe value, the two constant selections, a write landing only in its addressed row, and out-of-range writes leaving the store unchanged. Only the bench scenarios can show that each routed selection reaches the right pool signal on every row. The bench does this with its own slice-and-skew model, driving a single-hot pattern and its inverse at that signal. It also shows that a signal such as pool index 0 reaches rows 0, 11 and 22 but not row 12.

// File: rtl/xbar_pkg.sv
// Shared constants and the fixed first-level wiring rule of the sparse crossbar.
// Assumes the pool is split into N_ROUTED contiguous slices of SLICE_W signals,
// and the last slice takes whatever remains.
package xbar_pkg;
    localparam int POOL_W   = 65;
    localparam int ROWS     = 40;
    localparam int N_ROUTED = 6;
    localparam int N_CAND   = N_ROUTED + 2;
    localparam int SKEW     = 3;
    localparam int C_ONE    = 0;
    localparam int C_ZERO   = 1;
    localparam int C_ROUTE0 = 2;

    // Width of slice k for a pool of n_sig signals.
    function automatic int slice_len(input int k, input int n_sig);
        int w;
        int rem;
        w   = (n_sig + N_ROUTED - 1) / N_ROUTED;
        rem = n_sig - k * w;
        return (rem < w) ? rem : w;
    endfunction

    // Pool index wired to routed candidate k of a given row.
    function automatic int route_src(input int row, input int k, input int n_sig);
        int w;
        w = (n_sig + N_ROUTED - 1) / N_ROUTED;
        return k * w + ((row + SKEW * k) % slice_len(k, n_sig));
    endfunction
endpackage

// File: rtl/xbar_presel.sv
// First level: fixed per-row wiring of six routed candidates out of the pool.
// Pure wiring, no logic. Assumes every pool signal lands on at least one row.
module xbar_presel
    import xbar_pkg::*;
#(
    parameter int N_SIG = POOL_W,
    parameter int N_ROW = ROWS
) (
    input  logic [N_SIG-1:0]                  sig_in,
    output logic [N_ROW-1:0][N_ROUTED-1:0]    routed
);
    for (genvar r = 0; r < N_ROW; r++) begin : g_row
        for (genvar k = 0; k < N_ROUTED; k++) begin : g_cand
            // Tap the slice-k signal chosen for row r.
            assign routed[r][k] = sig_in[route_src(r, k, N_SIG)];
        end
    end
endmodule

// File: rtl/xbar_cfg_store.sv
// Holds the one-hot select word of each row and decodes writes from the load port.
// Assumes cfg_row is wide enough to address every row. Addresses past the last
// row are dropped.
module xbar_cfg_store
    import xbar_pkg::*;
#(
    parameter int N_ROW  = ROWS,
    parameter int ROW_AW = $clog2(N_ROW)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [ROW_AW-1:0]               cfg_row,
    input  logic [N_CAND-1:0]               cfg_sel,
    output logic [N_ROW-1:0][N_CAND-1:0]    sel_q
);
    logic in_range;

    // Accept only addresses that name an existing row.
    assign in_range = ({1'b0, cfg_row} < (ROW_AW + 1)'(N_ROW));

    for (genvar r = 0; r < N_ROW; r++) begin : g_row
        logic hit;
        assign hit = cfg_we && in_range && (cfg_row == ROW_AW'(r));

        // Capture this row's select word on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n)   sel_q[r] <= '0;
            else if (hit) sel_q[r] <= cfg_sel;
        end

        assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_row == ROW_AW'(r)) |=> (sel_q[r] == $past(cfg_sel)));
        assert_other_rows_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && cfg_row == ROW_AW'(r)) |=> $stable(sel_q[r]));
    end

    assert_out_of_range_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !in_range) |=> $stable(sel_q));
endmodule

// File: rtl/xbar_row.sv
// Second level of one row: a one-hot 8:1 AND-OR selector over the two constants
// and six routed candidates. The output is held at 1 until configuration is done,
// and also whenever the select word is not one-hot.
module xbar_row
    import xbar_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_ROUTED-1:0]   routed,
    input  logic [N_CAND-1:0]     sel,
    input  logic                  cfg_done,
    output logic                  row_out,
    output logic                  row_err
);
    logic [N_CAND-1:0] cand;
    logic              onehot;
    logic              picked;

    // Assemble the candidate list: constants first, then the routed taps.
    assign cand[C_ONE]  = 1'b1;
    assign cand[C_ZERO] = 1'b0;
    assign cand[N_CAND-1:C_ROUTE0] = routed;

    // A legal select word has exactly one bit set.
    assign onehot = (sel != '0) && ((sel & (sel - 1'b1)) == '0);

    // AND-OR selection; gated so only a single candidate can ever contribute.
    assign picked = |(cand & sel);

    // Force the safe level before configuration and on an illegal word.
    always_comb begin
        row_err = cfg_done && !onehot;
        row_out = (cfg_done && onehot) ? picked : 1'b1;
    end

    assert_safe_before_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> (row_out && !row_err));
    assert_err_holds_safe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        row_err |-> row_out);
    assert_const_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && sel == N_CAND'(1 << C_ONE)) |-> row_out);
    assert_const_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && sel == N_CAND'(1 << C_ZERO)) |-> !row_out);
endmodule

// File: rtl/xbar_sparse.sv
// Top of the sparse two-level crossbar. It connects the fixed pre-selection,
// the select-word store and one second-level selector per row.
// Assumes cfg_done stays low until every used row has been written.
module xbar_sparse
    import xbar_pkg::*;
#(
    parameter int N_SIG  = POOL_W,
    parameter int N_ROW  = ROWS,
    parameter int ROW_AW = $clog2(N_ROW)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SIG-1:0]     sig_in,
    input  logic                 cfg_we,
    input  logic [ROW_AW-1:0]    cfg_row,
    input  logic [N_CAND-1:0]    cfg_sel,
    input  logic                 cfg_done,
    output logic [N_ROW-1:0]     row_out,
    output logic [N_ROW-1:0]     row_err
);
    logic [N_ROW-1:0][N_ROUTED-1:0] routed;
    logic [N_ROW-1:0][N_CAND-1:0]   sel_q;

    xbar_presel #(.N_SIG(N_SIG), .N_ROW(N_ROW)) u_presel (
        .sig_in (sig_in),
        .routed (routed)
    );

    xbar_cfg_store #(.N_ROW(N_ROW), .ROW_AW(ROW_AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_row (cfg_row),
        .cfg_sel (cfg_sel),
        .sel_q   (sel_q)
    );

    for (genvar r = 0; r < N_ROW; r++) begin : g_row
        xbar_row u_row (
            .clk      (clk),
            .rst_n    (rst_n),
            .routed   (routed[r]),
            .sel      (sel_q[r]),
            .cfg_done (cfg_done),
            .row_out  (row_out[r]),
            .row_err  (row_err[r])
        );
    end
endmodule

// File: tb/xbar_sparse_tb.sv
module xbar_sparse_tb;
    localparam int NS = 65;
    localparam int NR = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] sig_in = '0;
    logic          cfg_we = 1'b0;
    logic [5:0]    cfg_row = '0;
    logic [7:0]    cfg_sel = '0;
    logic          cfg_done = 1'b0;
    logic [NR-1:0] row_out;
    logic [NR-1:0] row_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    xbar_sparse u_dut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .cfg_we(cfg_we),
        .cfg_row(cfg_row), .cfg_sel(cfg_sel), .cfg_done(cfg_done),
        .row_out(row_out), .row_err(row_err)
    );

    // Vectors: {row, select word, pool index driven high, expected row output}
    localparam logic [31:0] VEC [11] = '{
        {8'd0,  8'h04, 8'd0,  8'd1},   // R5 k=0 row 0 -> idx 0
        {8'd11, 8'h04, 8'd0,  8'd1},   // R5 k=0 row 11 -> idx 0
        {8'd12, 8'h04, 8'd0,  8'd0},   // R5 k=0 row 12 -> idx 1, not 0
        {8'd5,  8'h08, 8'd19, 8'd1},   // R5 k=1 row 5 -> idx 19
        {8'd5,  8'h08, 8'd18, 8'd0},   // R5 neighbour not routed
        {8'd22, 8'h10, 8'd28, 8'd1},   // R5 k=2 row 22 -> idx 28
        {8'd33, 8'h20, 8'd42, 8'd1},   // R5 k=3 row 33 -> idx 42
        {8'd7,  8'h40, 8'd52, 8'd1},   // R5 k=4 row 7 -> idx 52
        {8'd39, 8'h80, 8'd59, 8'd1},   // R5 k=5 row 39 -> idx 59
        {8'd3,  8'h01, 8'd0,  8'd1},   // R3 constant one
        {8'd3,  8'h02, 8'd0,  8'd0}    // R4 constant zero
    };

    function automatic int ref_src(input int row, input int k);
        int len;
        len = (k == 5) ? 10 : 11;
        return 11 * k + ((row + 3 * k) % len);
    endfunction

    function automatic logic [NS-1:0] hot(input int idx);
        logic [NS-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_sel(input int row, input logic [7:0] sel);
        @(negedge clk);
        cfg_we  = 1'b1;
        cfg_row = 6'(row);
        cfg_sel = sel;
        @(negedge clk);
        cfg_we  = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        sig_in = {NS{1'b1}} ^ hot(7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset row_out", 64'(row_out), 64'({NR{1'b1}}));
        chk("R1 reset row_err", 64'(row_err), 64'd0);
        cfg_done = 1'b1;
        #1;
        chk("R1/R6 cleared words err", 64'(row_err), 64'({NR{1'b1}}));
        chk("R1/R6 cleared words out", 64'(row_out), 64'({NR{1'b1}}));
        cfg_done = 1'b0;

        // Table walk
        for (int i = 0; i < 11; i++) begin
            write_sel(int'(VEC[i][31:24]), VEC[i][23:16]);
            sig_in   = hot(int'(VEC[i][15:8]));
            cfg_done = 1'b1;
            #1;
            chk($sformatf("R5 vector %0d", i), 64'(row_out[VEC[i][31:24]]), 64'(VEC[i][0]));
            cfg_done = 1'b0;
        end

        // Full sweep of every row and every selection
        for (int r = 0; r < NR; r++) begin
            for (int c = 0; c < 8; c++) begin
                logic e_hot;
                logic e_inv;
                int   src;
                write_sel(r, 8'(1 << c));
                cfg_done = 1'b1;
                src = (c >= 2) ? ref_src(r, c - 2) : 0;
                e_hot = (c == 0) ? 1'b1 : (c == 1) ? 1'b0 : 1'b1;
                e_inv = (c == 0) ? 1'b1 : 1'b0;
                sig_in = hot(src);
                #1;
                chk($sformatf("R5 row %0d sel %0d hot", r, c), 64'(row_out[r]), 64'(e_hot));
                chk($sformatf("R6 row %0d sel %0d no err", r, c), 64'(row_err[r]), 64'd0);
                sig_in = ~hot(src);
                #1;
                chk($sformatf("R5 row %0d sel %0d inverse", r, c), 64'(row_out[r]), 64'(e_inv));
            end
        end

        // R2: rows forced high while not done, all rows currently set
        cfg_done = 1'b0;
        sig_in   = '0;
        #1;
        chk("R2 forced high", 64'(row_out), 64'({NR{1'b1}}));
        chk("R2 no err while not done", 64'(row_err), 64'd0);

        // R6: multi-bit and zero select words
        write_sel(9, 8'h05);
        write_sel(10, 8'h00);
        cfg_done = 1'b1;
        sig_in   = '0;
        #1;
        chk("R6 multi-bit err", 64'(row_err[9]), 64'd1);
        chk("R6 multi-bit out", 64'(row_out[9]), 64'd1);
        chk("R6 zero word err", 64'(row_err[10]), 64'd1);
        chk("R6 zero word out", 64'(row_out[10]), 64'd1);

        // R7: a write touches only its own row
        for (int r = 0; r < NR; r++) write_sel(r, 8'h02);
        write_sel(4, 8'h01);
        #1;
        chk("R7 written row", 64'(row_out[4]), 64'd1);
        chk("R7 other rows", 64'(row_out), 64'(40'h1 << 4));

        // R8: out-of-range writes ignored
        write_sel(4, 8'h02);
        write_sel(40, 8'h01);
        write_sel(63, 8'h01);
        #1;
        chk("R8 out-of-range out", 64'(row_out), 64'd0);
        chk("R8 out-of-range err", 64'(row_err), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule